// File: doc/BRIEF.md
# Associative Translation Cache with Access Protection

This block holds recently used translations from 4 KB virtual pages to physical frames. Each slot carries its page number as a tag, so a lookup compares the page against every slot at once. In the same cycle the lookup reports a hit, a miss or a protection fault, and on a hit it gives the physical address. Each slot also keeps access and modification history: the reference and dirty bits are updated at the clock edge that ends a successful access.

A separate fill port installs a translation supplied by the walker, which lives outside this block. A fill that names a page already cached rewrites that slot in place. Any other fill replaces slots in strict rotation. A flush input drops every translation at once, for example on an address-space switch.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup splits the 32-bit address into a 20-bit page number (bits 31:12) and a 12-bit offset (bits 11:0). On a hit, in the same cycle, `lk_paddr` is the matching slot's frame number in bits 31:12 with the offset unchanged in bits 11:0.
- R2: A lookup whose page matches no valid slot raises `lk_miss`. Whenever `lk_hit` is low, `lk_paddr`, `lk_dirty` and `lk_ref` are zero.
- R3: At most one of `lk_hit`, `lk_miss` and `lk_fault` is high. All three are low when `lk_valid` is low.
- R4: A write (`lk_write`=1) to a matching slot whose write-permit bit is 0 raises `lk_fault` instead of `lk_hit`. A permit bit of 1 allows writes.
- R5: A user access (`lk_user`=1) to a matching slot whose user-permit bit is 0 raises `lk_fault`. Supervisor accesses (`lk_user`=0) ignore the user-permit bit.
- R6: On a hit, `lk_ref` and `lk_dirty` show the slot's bits as they stood before the access. A hit sets the reference bit at the next clock edge.
- R7: A write hit sets the slot's dirty bit. A faulting access changes neither the dirty bit nor the reference bit.
- R8: A fill of a page held by no valid slot writes the slot named by a rotating pointer and then advances the pointer, wrapping after the last slot. The new slot is valid with dirty and reference bits clear. After reset the pointer names slot 0, so with 8 slots the ninth new page evicts the first.
- R9: A fill of a page already held by a valid slot rewrites that slot's frame and permits, clears its dirty and reference bits, and leaves the pointer unchanged.
- R10: Flush invalidates every slot in one cycle and returns the pointer to slot 0. A fill in the same cycle is discarded.
- R11: After reset every slot is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Linear address to translate |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup comes from user level |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No valid translation |
| lk_fault | output | 1 | Translation found but access not permitted |
| lk_paddr | output | 32 | Physical address, zero unless hit |
| lk_dirty | output | 1 | Dirty bit of the hit slot before this access |
| lk_ref | output | 1 | Reference bit of the hit slot before this access |
| fill_en | input | 1 | Install a translation |
| fill_page | input | 20 | Page number to install |
| fill_frame | input | 20 | Frame number to install |
| fill_rw | input | 1 | Write permit of the new translation |
| fill_us | input | 1 | User permit of the new translation |
| flush | input | 1 | Invalidate all translations |

## Verification
The bench targets eviction order. It fills nine new pages and checks that the first is gone. A design that advanced the pointer on a refill of an existing page would evict the wrong slot, and a design that kept duplicate tags would show a stale frame. It also issues a flush together with a fill, which must leave the table empty, and writes to read-only pages, which must fault without marking them dirty. Random traffic over a small page pool then mixes these cases with back-to-back hits whose reported dirty and reference history exposes any update lost or applied at the wrong edge.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  input  logic        lk_write,
  input  logic        lk_user,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic        lk_fault,
  output logic [31:0] lk_paddr,
  output logic        lk_dirty,
  output logic        lk_ref,
  input  logic        fill_en,
  input  logic [19:0] fill_page,
  input  logic [19:0] fill_frame,
  input  logic        fill_rw,
  input  logic        fill_us,
  input  logic        flush
);

  logic [19:0]        page_q  [ENTRIES];
  logic [19:0]        frame_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, dty_q, ref_q, rw_q, us_q;
  logic [IDX_W-1:0]   ptr_q;

  logic             lk_match, fl_match;
  logic [IDX_W-1:0] lk_idx, fl_idx, fl_tgt;

  always_comb begin
    lk_match = 1'b0;
    lk_idx   = '0;
    fl_match = 1'b0;
    fl_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && page_q[i] == lk_addr[31:12]) begin
        lk_match = 1'b1;
        lk_idx   = IDX_W'(i);
      end
      if (vld_q[i] && page_q[i] == fill_page) begin
        fl_match = 1'b1;
        fl_idx   = IDX_W'(i);
      end
    end
  end

  wire denied = (lk_write && !rw_q[lk_idx]) || (lk_user && !us_q[lk_idx]);

  assign lk_fault = lk_valid && lk_match && denied;
  assign lk_hit   = lk_valid && lk_match && !denied;
  assign lk_miss  = lk_valid && !lk_match;
  assign lk_paddr = lk_hit ? {frame_q[lk_idx], lk_addr[11:0]} : 32'h0;
  assign lk_dirty = lk_hit && dty_q[lk_idx];
  assign lk_ref   = lk_hit && ref_q[lk_idx];
  assign fl_tgt   = fl_match ? fl_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
      dty_q <= '0;
      ref_q <= '0;
      ptr_q <= '0;
    end else begin
      if (lk_hit) begin
        ref_q[lk_idx] <= 1'b1;
        if (lk_write) dty_q[lk_idx] <= 1'b1;
      end
      if (fill_en) begin
        vld_q[fl_tgt]   <= 1'b1;
        dty_q[fl_tgt]   <= 1'b0;
        ref_q[fl_tgt]   <= 1'b0;
        rw_q[fl_tgt]    <= fill_rw;
        us_q[fl_tgt]    <= fill_us;
        page_q[fl_tgt]  <= fill_page;
        frame_q[fl_tgt] <= fill_frame;
        if (!fl_match)
          ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}) && (lk_valid || !(lk_hit || lk_miss || lk_fault))); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[11:0] == lk_addr[11:0]); // R1
  AST_QUIET_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == 32'h0 && !lk_dirty && !lk_ref)); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(lk_hit || lk_fault)); // R10
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> !(lk_valid && lk_addr[31:12] == $past(fill_page)) || !lk_miss); // R8
  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !fill_en && !flush) |=> dty_q[$past(lk_idx)] && ref_q[$past(lk_idx)]); // R7

endmodule

// File: tb/test_tlb_assoc.sv
`timescale 1ns/1ps
module test_tlb_assoc;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_addr = '0;
  logic fill_en = 0, fill_rw = 0, fill_us = 0, flush = 0;
  logic [19:0] fill_page = '0, fill_frame = '0;
  logic lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref;
  logic [31:0] lk_paddr;

  tlb_assoc #(.ENTRIES(N)) i_tlb_assoc (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;

  logic [19:0] m_page [N];
  logic [19:0] m_frame[N];
  logic        m_v[N], m_d[N], m_r[N], m_rw[N], m_us[N];
  int          m_ptr;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int find(logic [19:0] pg);
    for (int i = 0; i < N; i++) if (m_v[i] && m_page[i] == pg) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; end
    m_ptr = 0;
  endtask

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] a, bit w, bit u, bit fe, logic [19:0] fp,
                      logic [19:0] ff, bit frw, bit fus, bit fl, string tag);
    int idx, fi;
    bit eh, em, ef, ed, er;
    logic [31:0] ep;
    string t;
    @(negedge clk);
    lk_valid = v; lk_addr = a; lk_write = w; lk_user = u;
    fill_en = fe; fill_page = fp; fill_frame = ff; fill_rw = frw; fill_us = fus; flush = fl;
    #1;
    idx = find(a[31:12]);
    em = v && idx < 0;
    ef = v && idx >= 0 && ((w && !m_rw[idx]) || (u && !m_us[idx]));
    eh = v && idx >= 0 && !ef;
    ep = eh ? {m_frame[idx], a[11:0]} : 32'h0;
    ed = eh && m_d[idx];
    er = eh && m_r[idx];
    if (tag != "") t = tag;
    else if (!v) t = "R3";
    else if (em) t = "R2";
    else if (ef) t = (w && !m_rw[idx]) ? "R4" : "R5";
    else t = w ? "R7" : "R1";
    chk({lk_hit, lk_miss, lk_fault, lk_paddr} === {eh, em, ef, ep}, t,
        {29'h0, lk_hit, lk_miss, lk_fault, lk_paddr}, {29'h0, eh, em, ef, ep});
    if (eh)
      chk({lk_dirty, lk_ref} === {ed, er}, "R6", {62'h0, lk_dirty, lk_ref}, {62'h0, ed, er});
    if (fl) model_reset();
    else begin
      if (eh) begin m_r[idx] = 1; if (w) m_d[idx] = 1; end
      if (fe) begin
        fi = find(fp);
        if (fi < 0) begin fi = m_ptr; m_ptr = (m_ptr + 1) % N; end
        m_v[fi] = 1; m_d[fi] = 0; m_r[fi] = 0; m_rw[fi] = frw; m_us[fi] = fus;
        m_page[fi] = fp; m_frame[fi] = ff;
      end
    end
  endtask

  task automatic fill(logic [19:0] p, logic [19:0] f, bit rw, bit us);
    step(0, 0, 0, 0, 1, p, f, rw, us, 0, "R8");
  endtask

  task automatic look(logic [31:0] a, bit w, bit u, string tag);
    step(1, a, w, u, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(32'h0001_0FFF, 0, 0, "R11");
    look(32'h0000_0000, 0, 0, "R11");
    // R1 translation examples
    fill(20'h00010, 20'h12345, 1, 1);
    fill(20'h00004, 20'h10000, 1, 1);
    look(32'h0001_0FFF, 0, 0, "R1");
    look(32'h0000_4123, 0, 1, "R1");
    look(32'h1F00_5000, 0, 0, "R2");
    step(0, 32'h0001_0FFF, 1, 1, 0, 0, 0, 0, 0, 0, "R3");
    // R6 R7 history
    look(32'h0001_0000, 1, 0, "R7");
    look(32'h0001_0004, 0, 0, "R6");
    // R4 R5 protection
    fill(20'h00020, 20'hABCDE, 0, 0);
    look(32'h0002_0010, 1, 0, "R4");
    look(32'h0002_0010, 0, 1, "R5");
    look(32'h0002_0010, 0, 0, "R5");
    look(32'h0002_0010, 0, 0, "R7");
    // R9 refill in place, then R8 rotation
    fill(20'h00004, 20'h55555, 1, 0);
    look(32'h0000_4ABC, 0, 0, "R9");
    look(32'h0000_4ABC, 0, 1, "R9");
    for (int k = 0; k < 6; k++) fill(20'h00100 + 20'(k), 20'h20000 + 20'(k), 1, 1);
    fill(20'h00200, 20'h30000, 1, 1);
    look(32'h0001_0FFF, 0, 0, "R8");
    look(32'h0000_4000, 0, 0, "R8");
    look(32'h0020_0123, 0, 0, "R8");
    // R10 flush beats fill
    step(0, 0, 0, 0, 1, 20'h00300, 20'h44444, 1, 1, 1, "R10");
    look(32'h0030_0000, 0, 0, "R10");
    look(32'h0020_0000, 0, 0, "R10");
    fill(20'h00301, 20'h00001, 1, 1);
    look(32'h0030_1000, 0, 0, "R10");
    // random traffic over a small page pool
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], {16'h0, 4'(r[7:4]), r[19:8]}, r[2], r[3],
           r[20] & r[21], {16'h0, 4'(r[25:22])}, {12'h0, r[31:24]}, r[26], r[27],
           (r[31:28] == 4'hF) && r[0] && r[5], "");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule